// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is an I2C target that fronts a small array of byte registers held inside the block. A bus controller addresses it with a control byte: a 7-bit device address, set by a parameter, followed by a read/write flag. In a write transfer the first byte after the control byte loads an address pointer, and every later byte is stored at the pointer, which then steps forward. In a read transfer the block returns the byte at the pointer and steps the pointer after each byte it sends. The controller keeps the byte stream going by acknowledging and ends it by not acknowledging.

A single pointer serves every access. Reads, writes and address loads all leave it on the location after the last one touched, with wrap-around. Because of this, a read with no address phase continues from where the last access stopped. A write that carries only an address byte and is then cut short by a repeated START places the pointer for a random read. The bus pins come in already sampled on the system clock. SDA leaves the block as a pull-low enable that drives an open-drain pad.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, `sda_oe` is 0, every array byte reads as 0 and the pointer is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one aborts any transfer in progress at any bit. A START then expects a new control byte, and a STOP returns the block to idle.
- R3: The control byte is sent MSB first, with the device address in bits 7:1 and the direction in bit 0 (1 = read). On a match the block pulls SDA low for the ninth clock. On a mismatch it neither acknowledges nor drives SDA until the next START, and the array and the pointer stay as they were.
- R4: In a write, the first byte after the control byte sets the pointer from its low log2(DEPTH) bits and is acknowledged. Each later byte is stored at the pointer and acknowledged, and the pointer then steps by one.
- R5: A read that follows the control byte directly returns the byte at the current pointer.
- R6: A repeated START after the address byte of a write stores nothing. The next read then starts at that address.
- R7: When the controller acknowledges a read byte, the next byte follows. When it does not, the block stops driving, and after the STOP SDA stays released.
- R8: The pointer steps by one after each byte sent and wraps from DEPTH-1 to 0.
- R9: Read data goes out MSB first. `sda_oe` changes only while SCL is low, except when a START or STOP forces it off. The block releases SDA during the controller's acknowledge bit.
- R10: A data byte cut short by a STOP before its eighth bit is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench writes every location and then reads each one back twice: once by random read, and once by the current-address read that follows, which returns the next location. A pointer stepped at the wrong moment therefore shows up as a neighbour's value, and a missing wrap shows up at the top address. A sequential read of seventeen bytes crosses the wrap point, and a multi-byte write does the same. Both catch an address counter that saturates or fails to step during a burst. Further cases use a control byte that differs only in its lowest address bit, a data byte cut short by a STOP, and a START inside a byte. A design that decodes too few bits would acknowledge, one that writes partial bytes would corrupt a location, and one that does not restart would misframe the next control byte.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter logic [6:0] DEV_ADDR = 7'h52,
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_ACKC, S_ADDR, S_ACKA, S_WR, S_ACKW, S_RD, S_MACK
  } st_t;

  st_t st;
  logic scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] rsh, tsh;
  logic rw, mack;
  logic [AW-1:0] ptr;
  logic [7:0] mem [DEPTH];

  logic scl_rise, scl_fall, start_c, stop_c, rx, full, rd_done;

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  assign rx       = (st == S_CTRL) | (st == S_ADDR) | (st == S_WR);
  assign full     = (cnt == 4'd8);
  assign rd_done  = (st == S_RD) & scl_fall & (cnt == 4'd7);
  assign sda_oe   = (st == S_ACKC) | (st == S_ACKA) | (st == S_ACKW) |
                    ((st == S_RD) & ~tsh[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnt   <= '0;
      rsh   <= '0;
      tsh   <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      ptr   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        st  <= S_CTRL;
        cnt <= '0;
      end else if (stop_c) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (scl_rise) begin
        if (rx && !full) begin
          rsh <= {rsh[6:0], sda_i};
          cnt <= cnt + 4'd1;
        end
        if (st == S_MACK) mack <= ~sda_i;
      end else if (scl_fall) begin
        case (st)
          S_CTRL: if (full) begin
            cnt <= '0;
            if (rsh[7:1] == DEV_ADDR) begin
              rw <= rsh[0];
              st <= S_ACKC;
            end else begin
              st <= S_IDLE;
            end
          end
          S_ACKC: if (rw) begin
            tsh <= mem[ptr];
            st  <= S_RD;
          end else begin
            st  <= S_ADDR;
          end
          S_ADDR: if (full) begin
            cnt <= '0;
            ptr <= rsh[AW-1:0];
            st  <= S_ACKA;
          end
          S_ACKA, S_ACKW: st <= S_WR;
          S_WR: if (full) begin
            cnt      <= '0;
            mem[ptr] <= rsh;
            ptr      <= ptr + AW'(1);
            st       <= S_ACKW;
          end
          S_RD: if (cnt == 4'd7) begin
            cnt <= '0;
            ptr <= ptr + AW'(1);
            st  <= S_MACK;
          end else begin
            cnt <= cnt + 4'd1;
            tsh <= {tsh[6:0], 1'b0};
          end
          S_MACK: if (mack) begin
            tsh <= mem[ptr];
            st  <= S_RD;
          end else begin
            st  <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_mem_target_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          start_c,
  input logic          stop_c,
  input logic          rd_done,
  input logic [AW-1:0] ptr
);
  logic [AW-1:0] prev_ptr;
  always_ff @(posedge clk) prev_ptr <= ptr;

  assert_oe_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_oe));

  assert_oe_rise_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_release_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_c) |-> !sda_oe);

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_done) |-> ptr == prev_ptr + AW'(1));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_c(start_c), .stop_c(stop_c), .rd_done(rd_done), .ptr(ptr)
);

// File: tb/i2c_mem_target_test.sv
`timescale 1ns/100ps
module i2c_mem_target_test;
  localparam logic [6:0] DEV = 7'h52;
  localparam int N = 16;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] model [N];
  int mptr = 0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_mem_target #(.DEV_ADDR(DEV), .DEPTH(N)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); d[i] = sda_line; tick(Q); scl = 1'b0;
    end
    m_sda = ~give_ack; tick(Q); scl = 1'b1; tick(Q);
    chk("R9 released during controller ack", int'(sda_oe), 0);
    tick(Q); scl = 1'b0; tick(Q); m_sda = 1'b1;
  endtask

  task automatic read_burst(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(tag, int'(d), int'(model[mptr]));
      mptr = (mptr + 1) % N;
    end
    bus_stop;
    tick(Q);
    chk("R7 released after stop", int'(sda_oe), 0);
  endtask

  task automatic cur_read(input int n, input string tag);
    logic a;
    bus_start;
    send_byte({DEV, 1'b1}, a);
    chk("R3 control ack", int'(a), 1);
    read_burst(n, tag);
  endtask

  task automatic rand_read(input int adr, input int n, input string tag);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    chk("R3 control ack", int'(a), 1);
    send_byte(8'(adr), a);
    chk("R4 address ack", int'(a), 1);
    mptr = adr % N;
    bus_start;
    send_byte({DEV, 1'b1}, a);
    chk("R6 control ack after repeated start", int'(a), 1);
    read_burst(n, tag);
  endtask

  task automatic write_seq(input int adr, input int n, input int base);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    chk("R3 control ack", int'(a), 1);
    send_byte(8'(adr), a);
    chk("R4 address ack", int'(a), 1);
    mptr = adr % N;
    for (int k = 0; k < n; k++) begin
      send_byte(8'(base + 37 * k), a);
      chk("R4 data ack", int'(a), 1);
      model[mptr] = 8'(base + 37 * k);
      mptr = (mptr + 1) % N;
    end
    bus_stop;
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    tick(10);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 sda_oe idle", int'(sda_oe), 0);
    cur_read(2, "R1 zero array from pointer 0");

    for (int i = 0; i < N; i++) write_seq(i, 1, (i * 29 + 7) & 255);
    for (int i = 0; i < N; i++) begin
      rand_read(i, 1, "R6 random read");
      cur_read(1, "R5 R8 current read after random read");
    end

    rand_read(9, N + 1, "R7 R8 sequential read with wrap");

    write_seq(14, 4, 8'hC3);
    rand_read(14, 4, "R4 R8 multi-byte write with wrap");

    bus_start;
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    chk("R3 no ack on mismatch", int'(a), 0);
    send_byte(8'h03, a);
    chk("R3 ignored address byte", int'(a), 0);
    send_byte(8'hAA, a);
    chk("R3 ignored data byte", int'(a), 0);
    bus_stop;
    cur_read(1, "R3 pointer and array untouched by mismatch");

    bus_start;
    send_byte({DEV ^ 7'h40, 1'b1}, a);
    chk("R3 no ack on mismatched read", int'(a), 0);
    recv_byte(1'b0, d);
    chk("R3 no drive after mismatch", int'(d), 255);
    bus_stop;

    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h05, a);
    mptr = 5;
    send_bits(8'h00, 4);
    bus_stop;
    cur_read(1, "R10 partial byte not stored");

    bus_start;
    send_bits(8'hFF, 3);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    chk("R2 start inside a byte restarts framing", int'(a), 1);
    read_burst(1, "R2 read after mid-byte start");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule